// File: doc/BRIEF.md
# Status Word Field Writer

This block holds a processor's 32-bit current status word and one saved copy of it, and applies a move-to-status operation to either of them. The operation supplies an operand, two field-select bits and a target select. The operand is either a full register value or an 8-bit constant rotated right by an even amount. One select bit opens the top byte, which holds the condition flags. The other opens the low byte, which holds the interrupt masks, the instruction-set state bit and the mode.

A write to the current word is gated by privilege. The condition flags and the state bit can always be written. The mask and mode bits change only while the word's own mode field is not user mode. The mode's high bit is always held at one. A write to the saved word ignores privilege: it keeps only the architecturally defined bits of the selected bytes and always sets the mode high bit. When a write changes the current mode, the block raises a one-cycle strobe. The surrounding core uses this strobe to switch register banks. That switching, and refetching instructions after the write, belong to other blocks.

Top module: `psr_field_writer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the current word becomes 0x000000D3 (supervisor mode 0x13, both interrupt masks set), the saved word becomes 0x00000010, and `mode_chg` becomes 0.
- R2: With `use_imm` high, the operand is `imm8` zero-extended to 32 bits and rotated right by 2×`rot4` bit positions. With `use_imm` low, the operand is `reg_operand`.
- R3: A write to the current word with `sel_flags` high copies operand bits 31:28 into the word. Bits 27:8 of the current word never change after reset.
- R4: A write to the current word with `sel_ctrl` high copies operand bit 5 (the state bit) in every mode.
- R5: A write to the current word with `sel_ctrl` high copies operand bits 7:6 and 3:0 only when the word's mode field (bits 4:0) is not 5'b10000 (user). In user mode those bits are unchanged.
- R6: Bit 4 of the current word is 1 in every cycle, so a new mode is the operand's low nibble with bit 4 forced to 1.
- R7: A write to the saved word replaces the bits selected by (0xFF000000 if `sel_flags`) | (0x000000FF if `sel_ctrl`), ANDed with 0xF00000EF, with the operand's bits. It sets bit 4 even when no field is selected. All other bits keep their values.
- R8: A write changes only the word named by `to_saved` (1 = saved, 0 = current). With `wr_en` low, both words hold.
- R9: `mode_chg` is 1 for exactly the one cycle after a write edge that changed bits 4:0 of the current word, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Apply the operation at this clock edge |
| to_saved | input | 1 | 1 targets the saved word, 0 the current word |
| sel_flags | input | 1 | Enable the top (flags) byte |
| sel_ctrl | input | 1 | Enable the low (control) byte |
| use_imm | input | 1 | Take the rotated immediate as operand |
| reg_operand | input | 32 | Register operand |
| imm8 | input | 8 | Immediate constant |
| rot4 | input | 4 | Immediate rotate field; rotation is twice this value |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status word |
| mode_chg | output | 1 | One-cycle strobe on a change of the current mode |

## Verification
Several properties are checked on every cycle. The middle bits of both words never move, and the current word's mode high bit stays set. The privileged bits hold while the word is in user mode. An idle cycle or a write to the other target leaves a word untouched, and the strobe matches an actual change in the mode bits. The exact resulting values are shown only by the bench's sweep. That includes the immediate rotation, the per-field merge under every select and target combination, and the return to supervisor state on reset from user mode. The sweep compares each result with a model built from the masks.

// File: rtl/psr_pkg.sv
// Package: shared constants for the status word field writer.
// Assumes a 32-bit status word whose mode field occupies bits 4:0.
package psr_pkg;
    localparam int XLEN = 32;
    localparam int MODE_W = 5;

    localparam logic [XLEN-1:0] FLAGS_BYTE = 32'hFF00_0000;
    localparam logic [XLEN-1:0] CTRL_BYTE  = 32'h0000_00FF;
    localparam logic [XLEN-1:0] COND_BITS  = 32'hF000_0000;
    localparam logic [XLEN-1:0] PRIV_BITS  = 32'h0000_00CF;
    localparam logic [XLEN-1:0] STATE_BIT  = 32'h0000_0020;
    localparam logic [XLEN-1:0] MODE_HIGH  = 32'h0000_0010;
    localparam logic [XLEN-1:0] DEFINED_BITS = COND_BITS | PRIV_BITS | STATE_BIT;

    localparam logic [MODE_W-1:0] USER_MODE = 5'b10000;

    localparam logic [XLEN-1:0] CUR_RESET   = 32'h0000_00D3;
    localparam logic [XLEN-1:0] SAVED_RESET = 32'h0000_0010;
endpackage

// File: rtl/psr_operand_sel.sv
// Module: picks the write operand, either the register value or an
// immediate rotated right by twice the rotate field.
// Assumes 2*(2**ROT_W - 1) < XLEN so a single rotation suffices.
module psr_operand_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic             use_imm,
    input  logic [XLEN-1:0]  reg_operand,
    input  logic [IMM_W-1:0] imm,
    input  logic [ROT_W-1:0] rot,
    output logic [XLEN-1:0]  operand
);
    localparam int AMT_W = ROT_W + 1;

    logic [AMT_W-1:0]  rot_amt;
    logic [XLEN-1:0]   imm_ext;
    logic [2*XLEN-1:0] doubled;
    logic [2*XLEN-1:0] shifted;

    // Rotate the zero-extended immediate by shifting a doubled copy.
    always_comb begin
        rot_amt = {rot, 1'b0};
        imm_ext = XLEN'(imm);
        doubled = {imm_ext, imm_ext};
        shifted = doubled >> rot_amt;
        operand = use_imm ? shifted[XLEN-1:0] : reg_operand;
    end
endmodule

// File: rtl/psr_field_mask.sv
// Module: turns the two byte selects into the bit masks applied to the
// current and saved words; privileged control bits are dropped from the
// current-word mask while the held mode is user.
// Assumes the caller supplies in_user from the current word itself.
module psr_field_mask
    import psr_pkg::*;
(
    input  logic            sel_flags,
    input  logic            sel_ctrl,
    input  logic            in_user,
    output logic [XLEN-1:0] cur_mask,
    output logic [XLEN-1:0] saved_mask
);
    logic [XLEN-1:0] byte_mask;

    // Build the byte mask, then gate it per target.
    always_comb begin
        byte_mask = (sel_flags ? FLAGS_BYTE : '0) | (sel_ctrl ? CTRL_BYTE : '0);
        saved_mask = byte_mask & DEFINED_BITS;
        cur_mask = (sel_flags ? COND_BITS : '0)
                 | (sel_ctrl ? STATE_BIT : '0)
                 | ((sel_ctrl && !in_user) ? PRIV_BITS : '0);
    end
endmodule

// File: rtl/psr_cur_reg.sv
// Module: current status word register and mode-change strobe.
// Assumes mask never covers bit 4; that bit is forced to one on every write.
module psr_cur_reg
    import psr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [XLEN-1:0] mask,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] cur_q,
    output logic            mode_chg
);
    logic [XLEN-1:0] cur_next;

    // Merge the operand into the enabled bits and pin the mode high bit.
    always_comb begin
        cur_next = (cur_q & ~mask) | (operand & mask) | MODE_HIGH;
    end

    // Hold the word; strobe when a write moves the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= CUR_RESET;
            mode_chg <= 1'b0;
        end else begin
            mode_chg <= wr && (cur_next[MODE_W-1:0] != cur_q[MODE_W-1:0]);
            if (wr) begin
                cur_q <= cur_next;
            end
        end
    end

    // R3
    mid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cur_q[27:8]));
    // R6
    mode_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q[4]);
    // R5
    user_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cur_q[MODE_W-1:0] == USER_MODE) |=> ($stable(cur_q[7:6]) && $stable(cur_q[3:0]) && !mode_chg));
    // R9
    mode_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (cur_q[MODE_W-1:0] != $past(cur_q[MODE_W-1:0])));
    // R9
    quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> !mode_chg);
    // R8
    cur_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cur_q));
endmodule

// File: rtl/psr_saved_reg.sv
// Module: saved status word register.
// Assumes mask is already limited to the defined bits; bit 4 is set on
// every write regardless of mask.
module psr_saved_reg
    import psr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [XLEN-1:0] mask,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] saved_q
);
    // Load the merged value on a write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= SAVED_RESET;
        end else if (wr) begin
            saved_q <= (saved_q & ~mask) | (operand & mask) | MODE_HIGH;
        end
    end

    // R7
    saved_bit4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> saved_q[4]);
    // R7
    saved_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(saved_q[27:8]));
    // R8
    saved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(saved_q));
endmodule

// File: rtl/psr_field_writer.sv
// Module: top of the status word field writer. Selects the operand,
// derives per-target masks and updates the current or saved word.
// Assumes one operation per cycle, presented with wr_en at a clock edge.
module psr_field_writer
    import psr_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             to_saved,
    input  logic             sel_flags,
    input  logic             sel_ctrl,
    input  logic             use_imm,
    input  logic [XLEN-1:0]  reg_operand,
    input  logic [IMM_W-1:0] imm8,
    input  logic [ROT_W-1:0] rot4,
    output logic [XLEN-1:0]  cur_psr,
    output logic [XLEN-1:0]  saved_psr,
    output logic             mode_chg
);
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] cur_mask;
    logic [XLEN-1:0] saved_mask;
    logic            in_user;
    logic            cur_wr;
    logic            saved_wr;

    // Route the write to one target and read privilege from the held mode.
    always_comb begin
        cur_wr   = wr_en && !to_saved;
        saved_wr = wr_en && to_saved;
        in_user  = (cur_psr[MODE_W-1:0] == USER_MODE);
    end

    psr_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_opsel (
        .use_imm     (use_imm),
        .reg_operand (reg_operand),
        .imm         (imm8),
        .rot         (rot4),
        .operand     (operand)
    );

    psr_field_mask u_mask (
        .sel_flags  (sel_flags),
        .sel_ctrl   (sel_ctrl),
        .in_user    (in_user),
        .cur_mask   (cur_mask),
        .saved_mask (saved_mask)
    );

    psr_cur_reg u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cur_wr),
        .mask     (cur_mask),
        .operand  (operand),
        .cur_q    (cur_psr),
        .mode_chg (mode_chg)
    );

    psr_saved_reg u_saved (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (saved_wr),
        .mask    (saved_mask),
        .operand (operand),
        .saved_q (saved_psr)
    );

    // R8
    cur_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && to_saved) |=> $stable(cur_psr));
    // R8
    saved_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !to_saved) |=> $stable(saved_psr));
endmodule

// File: tb/tb_psr_field_writer.sv
module tb_psr_field_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        to_saved = 1'b0;
    logic        sel_flags = 1'b0;
    logic        sel_ctrl = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] reg_operand = '0;
    logic [7:0]  imm8 = '0;
    logic [3:0]  rot4 = '0;
    logic [31:0] cur_psr;
    logic [31:0] saved_psr;
    logic        mode_chg;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] ec;
    logic [31:0] es;
    logic        em;

    always #5 clk = ~clk;

    psr_field_writer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .to_saved(to_saved),
        .sel_flags(sel_flags), .sel_ctrl(sel_ctrl), .use_imm(use_imm),
        .reg_operand(reg_operand), .imm8(imm8), .rot4(rot4),
        .cur_psr(cur_psr), .saved_psr(saved_psr), .mode_chg(mode_chg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ror_imm(input logic [7:0] v, input logic [3:0] r);
        logic [63:0] d;
        d = {24'h0, v, 24'h0, v} >> (2 * r);
        return d[31:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ec = 32'h0000_00D3;
        es = 32'h0000_0010;
        chk("R1 cur", cur_psr, ec);
        chk("R1 saved", saved_psr, es);
        chk("R1 strobe", {31'h0, mode_chg}, 32'h0);
    endtask

    task automatic apply(input logic tsv, input logic fl, input logic ct,
                         input logic im, input logic [31:0] rv,
                         input logic [7:0] iv, input logic [3:0] rt);
        logic [31:0] op;
        logic [31:0] m;
        logic [31:0] n;
        @(negedge clk);
        to_saved = tsv; sel_flags = fl; sel_ctrl = ct; use_imm = im;
        reg_operand = rv; imm8 = iv; rot4 = rt; wr_en = 1'b1;
        op = im ? ror_imm(iv, rt) : rv;
        m = (fl ? 32'hFF00_0000 : 32'h0) | (ct ? 32'h0000_00FF : 32'h0);
        em = 1'b0;
        if (tsv) begin
            m = m & 32'hF000_00EF;
            es = (es & ~m) | (op & m) | 32'h10;
        end else begin
            n = ec;
            if (fl) n = (n & 32'h0FFF_FFFF) | (op & 32'hF000_0000);
            if (ct) n = (n & ~32'h20) | (op & 32'h20);
            if (ct && ec[4:0] != 5'b10000) n = (n & ~32'hCF) | (op & 32'hCF) | 32'h10;
            em = (n[4:0] != ec[4:0]);
            ec = n;
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 R3 R4 R5 R6 R8 cur", cur_psr, ec);
        chk("R2 R7 R8 saved", saved_psr, es);
        chk("R9 strobe", {31'h0, mode_chg}, {31'h0, em});
        @(negedge clk);
        chk("R9 strobe drop", {31'h0, mode_chg}, 32'h0);
        chk("R8 idle cur", cur_psr, ec);
        chk("R8 idle saved", saved_psr, es);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2 directed: 0xFF rotated right by 2 into saved with both bytes
        apply(1'b1, 1'b1, 1'b1, 1'b1, 32'h0, 8'hFF, 4'd1);
        chk("R2 R7 rotated immediate", saved_psr, 32'hC000_003F);

        // R5 directed: enter user mode, then a control write must not leave it
        apply(1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0010, 8'h0, 4'd0);
        chk("R5 entered user", cur_psr, 32'h0000_0010);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 32'hA000_00FF, 8'h0, 4'd0);
        chk("R3 R4 R5 user write", cur_psr, 32'hA000_0030);

        // R1 reset from user mode
        do_reset();

        // Sweep over target, selects, operand source and operand values
        for (int i = 0; i < 512; i++) begin
            logic [31:0] v;
            v = (i * 32'h9E37_79B1) ^ (i << 3) ^ 32'h0000_0013;
            apply(i[2], i[1], i[0], i[3], v, v[7:0], v[11:8]);
            if ((i % 11) == 10) do_reset();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule